// File: doc/BRIEF.md
# Packed Depth-Stencil Read-Modify-Write Unit

This unit carries out single-pixel depth and stencil accesses against a surface that packs a 24-bit depth value and an 8-bit stencil value into each 32-bit memory word. It also serves surfaces that hold plain 16-bit depth values. A client sends one request at a time. Each request names an operation, a byte address and up to 24 bits of write data. The unit drives a simple synchronous memory port whose read data returns one cycle after the read is issued.

Writing one field of a packed word must leave the other field intact. The unit therefore reads the word, replaces only the target field and writes the word back. Reads return the selected field right-aligned on a response channel. The response is held until the client accepts it.

A layout input sets which end of the word holds the stencil byte, and a mode input selects 16-bit depth handling. Both are captured when a request is accepted.

Top module: `zs_rmw_unit`

## Requirements
- R1: While reset is asserted and on the cycle after it, `req_ready` is 1, `rsp_valid` is 0 and `mem_en` is 0.
- R2: Operation encoding is 0 = depth read, 1 = depth write, 2 = stencil read, 3 = stencil write. With `cfg_stencil_hi`=0, depth lives in word bits 31:8 and stencil in bits 7:0. A depth write then stores `{wdata[23:0], old[7:0]}`.
- R3: With `cfg_stencil_hi`=1, stencil lives in bits 31:24 and depth in bits 23:0. A depth write then stores `{old[31:24], wdata[23:0]}`.
- R4: A stencil write keeps the 24 depth bits of the old word and inserts `wdata[7:0]` into the stencil byte of the selected layout.
- R5: A depth read returns the 24-bit depth field zero-extended in `rsp_data`. A stencil read returns the 8-bit stencil field zero-extended.
- R6: With `cfg_z16`=1, operation bit 1 is ignored. A write issues no read and stores `wdata[15:0]` in one half-word: byte address bit 1 = 0 selects bits 15:0 with `mem_be`=0011, and bit 1 = 1 selects bits 31:16 with `mem_be`=1100. A read returns the selected half-word zero-extended.
- R7: A packed write issues exactly one read and then, two cycles later, one full-word write to the same word address. `req_ready` is low from acceptance until the unit is idle again.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_data` stays unchanged.
- R9: `cfg_stencil_hi` and `cfg_z16` are sampled when a request is accepted. Changes to them during the operation have no effect on that operation.
- R10: `mem_addr` is the request byte address shifted right by two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_stencil_hi | input | 1 | 1: stencil in the top byte; 0: stencil in the bottom byte |
| cfg_z16 | input | 1 | 1: plain 16-bit depth surface |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle; accepts a request |
| req_op | input | 2 | Operation code |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 24 | Write value (depth, stencil or half-word) |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Client takes the result |
| rsp_data | output | 32 | Right-aligned read result |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read |

## Verification
The assertions assume that the memory returns read data exactly one cycle after a read strobe. They also assume that the client raises `req_valid` only as a single-beat request and does not expect a response to writes. The bench memory model has that fixed latency. The stimulus issues each request only while `req_ready` is high and waits for the unit to return to idle before it sends the next one. The layout input is changed in the middle of an operation only in the dedicated test, which checks that the change is ignored.

// File: rtl/zs_pkg.sv
package zs_pkg;
    localparam int DEPTH_W = 24;
    localparam int STEN_W  = 8;
    localparam int WORD_W  = DEPTH_W + STEN_W;
    localparam int HALF_W  = WORD_W / 2;
    localparam int BE_W    = WORD_W / 8;

    typedef enum logic [1:0] {
        OP_RD_Z = 2'd0,
        OP_WR_Z = 2'd1,
        OP_RD_S = 2'd2,
        OP_WR_S = 2'd3
    } zs_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_MERGE,
        ST_WRITE,
        ST_RESPOND
    } zs_state_e;

    typedef struct packed {
        logic stencil_hi;
        logic z16;
    } zs_cfg_t;

    function automatic logic op_is_write(input zs_op_e op);
        return op[0];
    endfunction

    function automatic logic op_is_stencil(input zs_op_e op);
        return op[1];
    endfunction
endpackage

// File: rtl/zs_field.sv
module zs_field
    import zs_pkg::*;
(
    input  logic [WORD_W-1:0]  old_word,
    input  logic [DEPTH_W-1:0] new_val,
    input  logic               stencil_hi,
    input  logic               sel_stencil,
    input  logic               half_hi,
    output logic [WORD_W-1:0]  merged,
    output logic [WORD_W-1:0]  packed_rd,
    output logic [WORD_W-1:0]  half_rd
);
    logic [DEPTH_W-1:0] depth_f, depth_n;
    logic [STEN_W-1:0]  sten_f, sten_n;

    always_comb begin
        if (stencil_hi) begin
            depth_f = old_word[DEPTH_W-1:0];
            sten_f  = old_word[WORD_W-1 -: STEN_W];
        end else begin
            depth_f = old_word[WORD_W-1 -: DEPTH_W];
            sten_f  = old_word[STEN_W-1:0];
        end
        depth_n = sel_stencil ? depth_f : new_val;
        sten_n  = sel_stencil ? new_val[STEN_W-1:0] : sten_f;
        merged  = stencil_hi ? {sten_n, depth_n} : {depth_n, sten_n};
        if (sel_stencil)
            packed_rd = {{(WORD_W-STEN_W){1'b0}}, sten_f};
        else
            packed_rd = {{(WORD_W-DEPTH_W){1'b0}}, depth_f};
        half_rd = {{HALF_W{1'b0}},
                   half_hi ? old_word[WORD_W-1:HALF_W] : old_word[HALF_W-1:0]};
    end
endmodule

// File: rtl/zs_seq.sv
module zs_seq
    import zs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      accept,
    input  logic      acc_write,
    input  logic      acc_z16,
    input  logic      cur_write,
    input  logic      rsp_ready,
    output zs_state_e state
);
    zs_state_e state_n;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:    if (accept) state_n = (acc_write && acc_z16) ? ST_WRITE : ST_READ;
            ST_READ:    state_n = ST_MERGE;
            ST_MERGE:   state_n = cur_write ? ST_WRITE : ST_RESPOND;
            ST_WRITE:   state_n = ST_IDLE;
            ST_RESPOND: if (rsp_ready) state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_n;
    end
endmodule

// File: rtl/zs_rmw_unit.sv
module zs_rmw_unit
    import zs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_stencil_hi,
    input  logic                 cfg_z16,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [1:0]           req_op,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DEPTH_W-1:0]   req_wdata,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic [WORD_W-1:0]    rsp_data,
    output logic                 mem_en,
    output logic                 mem_we,
    output logic [ADDR_W-3:0]    mem_addr,
    output logic [BE_W-1:0]      mem_be,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic [WORD_W-1:0]    mem_rdata
);
    localparam int WA_W = ADDR_W - 2;
    localparam logic [BE_W-1:0] BE_ALL = '1;
    localparam logic [BE_W-1:0] BE_LO  = {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}};
    localparam logic [BE_W-1:0] BE_HI  = ~BE_LO;

    zs_state_e          state;
    zs_op_e             op_q;
    zs_cfg_t            cfg_q;
    logic [WA_W-1:0]    waddr_q;
    logic               half_q;
    logic [DEPTH_W-1:0] wdata_q;
    logic [WORD_W-1:0]  word_q;
    logic               accept;
    logic [WORD_W-1:0]  merged, packed_rd, half_rd;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    zs_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .acc_write (req_op[0]),
        .acc_z16   (cfg_z16),
        .cur_write (op_is_write(op_q)),
        .rsp_ready (rsp_ready),
        .state     (state)
    );

    zs_field u_field (
        .old_word    (mem_rdata),
        .new_val     (wdata_q),
        .stencil_hi  (cfg_q.stencil_hi),
        .sel_stencil (op_is_stencil(op_q)),
        .half_hi     (half_q),
        .merged      (merged),
        .packed_rd   (packed_rd),
        .half_rd     (half_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= OP_RD_Z;
            cfg_q   <= '0;
            waddr_q <= '0;
            half_q  <= 1'b0;
            wdata_q <= '0;
            word_q  <= '0;
        end else begin
            if (accept) begin
                op_q           <= zs_op_e'(req_op);
                cfg_q.stencil_hi <= cfg_stencil_hi;
                cfg_q.z16      <= cfg_z16;
                waddr_q        <= req_addr[ADDR_W-1:2];
                half_q         <= req_addr[1];
                wdata_q        <= req_wdata;
            end
            if (state == ST_MERGE) begin
                if (cfg_q.z16)                  word_q <= half_rd;
                else if (op_is_write(op_q))     word_q <= merged;
                else                            word_q <= packed_rd;
            end
        end
    end

    always_comb begin
        mem_en    = (state == ST_READ) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        mem_addr  = waddr_q;
        mem_be    = BE_ALL;
        mem_wdata = word_q;
        if (cfg_q.z16) begin
            mem_wdata = {2{wdata_q[HALF_W-1:0]}};
            if (state == ST_WRITE) mem_be = half_q ? BE_HI : BE_LO;
        end
    end

    assign rsp_valid = (state == ST_RESPOND);
    assign rsp_data  = word_q;
endmodule

// File: rtl/zs_rmw_checker.sv
module zs_rmw_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [31:0]       rsp_data,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-3:0] mem_addr,
    input logic [3:0]        mem_be
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (req_ready && !rsp_valid && !mem_en));

    p_rsp_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_rsp_not_idle_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    p_rmw_order_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we && mem_be == 4'hF) |->
            ($past(mem_en && !mem_we, 2) && $past(mem_addr, 2) == mem_addr));

    p_half_be_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we && mem_be != 4'hF) |->
            ($countones(mem_be) == 2 && (mem_be == 4'h3 || mem_be == 4'hC)));
endmodule

bind zs_rmw_unit zs_rmw_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be)
);

// File: tb/zs_rmw_unit_test.sv
module zs_rmw_unit_test;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_stencil_hi = 1'b0;
    logic              cfg_z16 = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [23:0]       req_wdata = '0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b0;
    logic [31:0]       rsp_data;
    logic              mem_en, mem_we;
    logic [ADDR_W-3:0] mem_addr;
    logic [3:0]        mem_be;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata = '0;

    logic [31:0] mem [0:15];
    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;

    always #4 clk = ~clk;

    zs_rmw_unit #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .cfg_stencil_hi(cfg_stencil_hi), .cfg_z16(cfg_z16),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_data(rsp_data), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                wr_cnt <= wr_cnt + 1;
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[3:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            end else begin
                rd_cnt <= rd_cnt + 1;
                mem_rdata <= mem[mem_addr[3:0]];
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [ADDR_W-1:0] a, input logic [23:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20; i++) begin
            if (req_ready) break;
            @(negedge clk);
        end
    endtask

    task automatic do_write(input string tag, input logic [1:0] op, input logic [ADDR_W-1:0] a,
                            input logic [23:0] d, input logic [31:0] exp, input int exp_rd);
        int rd0, wr0;
        rd0 = rd_cnt; wr0 = wr_cnt;
        issue(op, a, d);
        wait_idle();
        check(tag, mem[a[5:2]], exp);
        check({tag, " R7 reads"}, rd_cnt - rd0, exp_rd);
        check({tag, " R7 writes"}, wr_cnt - wr0, 1);
    endtask

    task automatic do_read(input string tag, input logic [1:0] op, input logic [ADDR_W-1:0] a,
                           input logic [31:0] exp, input int hold);
        issue(op, a, 24'h0);
        for (int i = 0; i < 20; i++) begin
            if (rsp_valid) break;
            @(negedge clk);
        end
        check({tag, " valid"}, rsp_valid, 1);
        check(tag, rsp_data, exp);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check("R8 hold valid", rsp_valid, 1);
            check("R8 hold data", rsp_data, exp);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check("R8 released", rsp_valid, 0);
        wait_idle();
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 ready", req_ready, 1);
        check("R1 rsp_valid", rsp_valid, 0);
        check("R1 mem_en", mem_en, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after", req_ready, 1);
    endtask

    task automatic t_layout_low();
        cfg_stencil_hi = 1'b0;
        do_write("R2 depth write low", 2'd1, 16'd4, 24'h123456, 32'h1234_56EF, 1);
        do_write("R4 stencil write low", 2'd3, 16'd4, 24'hFFFF5A, 32'h1234_565A, 1);
        do_read("R5 depth read low", 2'd0, 16'd4, 32'h0012_3456, 3);
        do_read("R5 stencil read low", 2'd2, 16'd4, 32'h0000_005A, 0);
    endtask

    task automatic t_layout_high();
        cfg_stencil_hi = 1'b1;
        do_write("R3 depth write high", 2'd1, 16'd8, 24'hABCDEF, 32'h11AB_CDEF, 1);
        do_write("R4 stencil write high", 2'd3, 16'd8, 24'h000077, 32'h77AB_CDEF, 1);
        do_read("R5 depth read high", 2'd0, 16'd8, 32'h00AB_CDEF, 2);
        do_read("R5 stencil read high", 2'd2, 16'd8, 32'h0000_0077, 0);
        cfg_stencil_hi = 1'b0;
    endtask

    task automatic t_z16();
        cfg_z16 = 1'b1;
        do_write("R6 half write low", 2'd1, 16'd12, 24'hEE1234, 32'hCAFE_1234, 0);
        do_write("R6 half write high", 2'd3, 16'd14, 24'h005678, 32'h5678_1234, 0);
        do_read("R6 half read high", 2'd0, 16'd14, 32'h0000_5678, 1);
        do_read("R6 half read low", 2'd2, 16'd12, 32'h0000_1234, 0);
        cfg_z16 = 1'b0;
    endtask

    task automatic t_cfg_change();
        cfg_stencil_hi = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_addr = 16'd16; req_wdata = 24'h0A0B0C;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_stencil_hi = 1'b1;
        cfg_z16 = 1'b1;
        wait_idle();
        cfg_stencil_hi = 1'b0;
        cfg_z16 = 1'b0;
        check("R9 layout held R10 addr", mem[4], 32'h0A0B_0C04);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h0;
        mem[1] = 32'hDEAD_BEEF;
        mem[2] = 32'h1122_3344;
        mem[3] = 32'hCAFE_F00D;
        mem[4] = 32'h0102_0304;
        repeat (3) @(posedge clk);
        t_reset();
        t_layout_low();
        t_layout_high();
        t_z16();
        t_cfg_change();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule